// File: doc/BRIEF.md
# IN Control Endpoint Handshake and Control State

This block keeps the control state of one USB device IN control endpoint and chooses, at every moment, the handshake that endpoint would answer an incoming token with: send DATA, answer NAK, or answer STALL. Software reaches the state through a small register port. Single-cycle write strobes select one of three registers. A combinational read port returns any register. The endpoint core reports three events as single-cycle pulses: a SETUP packet arrived, a transfer finished, or a requested disable has been carried out.

Some control bits are cleared by hardware. The enable bit drops when a transfer finishes or a disable completes. The disable request drops when the core confirms it. The matching interrupt flag rises exactly one cycle after the bit has dropped, so software never finds a raised flag next to a bit that still reads set. The block also gates each IN endpoint's TX-FIFO-empty indication with a per-endpoint mask bit.

Register map (address on `reg_addr` / `reg_raddr`):

- Address 0, control:
  - bit 0 enable
  - bit 1 disable request
  - bit 2 set-NAK strobe
  - bit 3 clear-NAK strobe
  - bit 4 stall
  - bits 11:8 TX FIFO number
  - bit 16 NAK status (read-only)
- Address 1, interrupt flags (write one to clear):
  - bit 0 endpoint disabled
  - bit 1 transfer complete
- Address 2, TX-FIFO-empty mask: bit n belongs to IN endpoint n.

Top module: `inep_ctrl_hs`

## Requirements
- R1: After synchronous reset every register reads zero, both interrupt outputs are low, and the handshake code is NAK (1).
- R2: Writing 1 to control bit 0 sets enable. Writing 0 there leaves enable unchanged.
- R3: A transfer-complete pulse while enable is set clears enable at the next edge (hardware clear wins over a same-cycle software set). The transfer-complete flag (flag bit 1, output irq_xfer_cmpl) rises one edge later.
- R4: Writing 1 to control bit 1 sets the disable request only when enable is already set; otherwise the write has no effect. A disable-complete pulse while the request is set clears both enable and the request. The disabled flag (flag bit 0, output irq_ep_dis) rises one edge later.
- R5: Writing 1 to control bit 2 sets the NAK status (bit 16) and writing 1 to bit 3 clears it. If both are written together, set wins. Bits 2 and 3 always read back as 0.
- R6: A SETUP pulse sets the NAK status and clears stall, even when software writes stall in the same cycle.
- R7: Writing 1 to control bit 4 sets stall. Writing 0 never clears it; only a SETUP pulse does.
- R8: Handshake code (DATA=0, NAK=1, STALL=2): STALL when stall is set; otherwise NAK when the NAK status, the global nonperiodic IN NAK or the global OUT NAK is set; otherwise DATA when enable is set; otherwise NAK.
- R9: Control bits 11:8 hold the FIFO number, written on every control write. All unlisted bits of every register read as 0.
- R10: The mask register (address 2) holds NUM_EP bits. Each bit of irq_txf_empty equals the matching txf_empty input ANDed with its mask bit.
- R11: Interrupt flags stay set until software writes 1 to the matching bit of address 1. A raise in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Write address |
| reg_wdata | input | DATA_W | Write data |
| reg_raddr | input | ADDR_W | Read address |
| reg_rdata | output | DATA_W | Read data (combinational) |
| core_setup | input | 1 | SETUP packet received pulse |
| core_xfer_done | input | 1 | Transfer completed pulse |
| core_dis_done | input | 1 | Disable carried out pulse |
| glb_np_in_nak | input | 1 | Global nonperiodic IN NAK |
| glb_out_nak | input | 1 | Global OUT NAK |
| txf_empty | input | NUM_EP | TX-FIFO-empty indication per IN endpoint |
| hs_code | output | 2 | Handshake choice: 0 DATA, 1 NAK, 2 STALL |
| irq_ep_dis | output | 1 | Endpoint disabled interrupt flag |
| irq_xfer_cmpl | output | 1 | Transfer complete interrupt flag |
| irq_txf_empty | output | NUM_EP | Masked TX-FIFO-empty interrupts |

## Verification
The bench builds the block with its defaults: NUM_EP of 7, a 4-bit FIFO number and 32-bit data. With seven endpoints, every mask bit and every empty line can be toggled on its own. The 4-bit FIFO field and the full 32-bit control word bring every reserved bit into reach of random writes. Random sequences mix core pulses with register writes at high density. This makes the same-cycle collisions routine: set/clear NAK, SETUP against stall, hardware clear against software set, and flag raise against clear. Directed cases pin each of these collisions once.

// File: rtl/inep_hs_pkg.sv
package inep_hs_pkg;

    typedef enum logic [1:0] {
        HS_DATA  = 2'd0,
        HS_NAK   = 2'd1,
        HS_STALL = 2'd2
    } hs_e;

    // control word layout
    localparam int CTL_EN_B     = 0;
    localparam int CTL_DIS_B    = 1;
    localparam int CTL_SNAK_B   = 2;
    localparam int CTL_CNAK_B   = 3;
    localparam int CTL_STALL_B  = 4;
    localparam int CTL_FIFO_LSB = 8;
    localparam int CTL_NAKST_B  = 16;

    // interrupt flag layout
    localparam int INT_DIS_B  = 0;
    localparam int INT_XFER_B = 1;
    localparam int INT_W      = 2;

    // register addresses
    localparam int A_CTL  = 0;
    localparam int A_INT  = 1;
    localparam int A_MASK = 2;

    typedef struct packed {
        logic en;
        logic dis;
        logic nak;
        logic stall;
    } ep_state_t;

    function automatic hs_e pick_hs(input logic stall, input logic nak_any,
                                    input logic en);
        if (stall)        return HS_STALL;
        else if (nak_any) return HS_NAK;
        else if (en)      return HS_DATA;
        else              return HS_NAK;
    endfunction

endpackage

// File: rtl/inep_ctl_regs.sv
module inep_ctl_regs
    import inep_hs_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int FIFO_W = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_ctl,
    input  logic                    wr_int,
    input  logic [DATA_W-1:0]       wdata,
    input  logic                    setup,
    input  logic                    xfer_done,
    input  logic                    dis_done,
    output ep_state_t               st,
    output logic [FIFO_W-1:0]       fifo_num,
    output logic [INT_W-1:0]        flags
);

    ep_state_t          st_n;
    logic [INT_W-1:0]   pend_q, pend_n, flags_n;
    logic [INT_W-1:0]   clr_mask;

    always_comb begin
        st_n = st;
        pend_n = '0;

        // software side
        if (wr_ctl && wdata[CTL_EN_B])
            st_n.en = 1'b1;
        if (wr_ctl && wdata[CTL_DIS_B] && st.en)
            st_n.dis = 1'b1;
        if (wr_ctl && wdata[CTL_CNAK_B])
            st_n.nak = 1'b0;
        if (wr_ctl && wdata[CTL_SNAK_B])
            st_n.nak = 1'b1;
        if (wr_ctl && wdata[CTL_STALL_B])
            st_n.stall = 1'b1;

        // hardware side overrides
        if (setup) begin
            st_n.nak   = 1'b1;
            st_n.stall = 1'b0;
        end
        if (xfer_done && st.en) begin
            st_n.en = 1'b0;
            pend_n[INT_XFER_B] = 1'b1;
        end
        if (dis_done && st.dis) begin
            st_n.en  = 1'b0;
            st_n.dis = 1'b0;
            pend_n[INT_DIS_B] = 1'b1;
        end

        clr_mask = wr_int ? wdata[INT_W-1:0] : '0;
        flags_n  = (flags & ~clr_mask) | pend_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= '0;
            pend_q   <= '0;
            flags    <= '0;
            fifo_num <= '0;
        end else begin
            st     <= st_n;
            pend_q <= pend_n;
            flags  <= flags_n;
            if (wr_ctl)
                fifo_num <= wdata[CTL_FIFO_LSB +: FIFO_W];
        end
    end

endmodule

// File: rtl/inep_hs_arb.sv
module inep_hs_arb
    import inep_hs_pkg::*;
(
    input  ep_state_t st,
    input  logic      glb_np_in_nak,
    input  logic      glb_out_nak,
    output hs_e       hs
);

    logic nak_any;

    always_comb begin
        nak_any = st.nak | glb_np_in_nak | glb_out_nak;
        hs      = pick_hs(st.stall, nak_any, st.en);
    end

endmodule

// File: rtl/inep_txf_gate.sv
module inep_txf_gate #(
    parameter int NUM_EP = 7,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_mask,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NUM_EP-1:0] empty,
    output logic [NUM_EP-1:0] mask,
    output logic [NUM_EP-1:0] irq
);

    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
        always_ff @(posedge clk) begin
            if (rst)
                mask[g] <= 1'b0;
            else if (wr_mask)
                mask[g] <= wdata[g];
        end
        assign irq[g] = empty[g] & mask[g];
    end

endmodule

// File: rtl/inep_ctrl_hs.sv
module inep_ctrl_hs
    import inep_hs_pkg::*;
#(
    parameter int NUM_EP = 7,
    parameter int FIFO_W = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [ADDR_W-1:0] reg_raddr,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              core_setup,
    input  logic              core_xfer_done,
    input  logic              core_dis_done,
    input  logic              glb_np_in_nak,
    input  logic              glb_out_nak,
    input  logic [NUM_EP-1:0] txf_empty,
    output logic [1:0]        hs_code,
    output logic              irq_ep_dis,
    output logic              irq_xfer_cmpl,
    output logic [NUM_EP-1:0] irq_txf_empty
);

    localparam logic [ADDR_W-1:0] AD_CTL  = ADDR_W'(A_CTL);
    localparam logic [ADDR_W-1:0] AD_INT  = ADDR_W'(A_INT);
    localparam logic [ADDR_W-1:0] AD_MASK = ADDR_W'(A_MASK);

    ep_state_t          st;
    logic [FIFO_W-1:0]  fifo_num;
    logic [INT_W-1:0]   flags;
    logic [NUM_EP-1:0]  txf_mask;
    hs_e                hs;
    logic               wr_ctl, wr_int, wr_mask;

    assign wr_ctl  = reg_wr && (reg_addr == AD_CTL);
    assign wr_int  = reg_wr && (reg_addr == AD_INT);
    assign wr_mask = reg_wr && (reg_addr == AD_MASK);

    inep_ctl_regs #(.DATA_W(DATA_W), .FIFO_W(FIFO_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_ctl    (wr_ctl),
        .wr_int    (wr_int),
        .wdata     (reg_wdata),
        .setup     (core_setup),
        .xfer_done (core_xfer_done),
        .dis_done  (core_dis_done),
        .st        (st),
        .fifo_num  (fifo_num),
        .flags     (flags)
    );

    inep_hs_arb u_arb (
        .st            (st),
        .glb_np_in_nak (glb_np_in_nak),
        .glb_out_nak   (glb_out_nak),
        .hs            (hs)
    );

    inep_txf_gate #(.NUM_EP(NUM_EP), .DATA_W(DATA_W)) u_txf (
        .clk     (clk),
        .rst     (rst),
        .wr_mask (wr_mask),
        .wdata   (reg_wdata),
        .empty   (txf_empty),
        .mask    (txf_mask),
        .irq     (irq_txf_empty)
    );

    assign hs_code       = hs;
    assign irq_ep_dis    = flags[INT_DIS_B];
    assign irq_xfer_cmpl = flags[INT_XFER_B];

    always_comb begin
        reg_rdata = '0;
        if (reg_raddr == AD_CTL) begin
            reg_rdata[CTL_EN_B]                  = st.en;
            reg_rdata[CTL_DIS_B]                 = st.dis;
            reg_rdata[CTL_STALL_B]               = st.stall;
            reg_rdata[CTL_FIFO_LSB +: FIFO_W]    = fifo_num;
            reg_rdata[CTL_NAKST_B]               = st.nak;
        end else if (reg_raddr == AD_INT) begin
            reg_rdata[INT_W-1:0] = flags;
        end else if (reg_raddr == AD_MASK) begin
            reg_rdata[NUM_EP-1:0] = txf_mask;
        end
    end

endmodule

// File: rtl/inep_hs_chk.sv
module inep_hs_chk #(
    parameter int NUM_EP = 7,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              core_setup,
    input logic [1:0]        hs_code,
    input logic              irq_ep_dis,
    input logic              irq_xfer_cmpl,
    input logic [NUM_EP-1:0] irq_txf_empty,
    input logic              st_en,
    input logic              st_dis,
    input logic              st_nak,
    input logic              st_stall,
    input logic [NUM_EP-1:0] txf_mask
);

    // R8: stall outranks every NAK source
    p_stall_first_r8: assert property (@(posedge clk) disable iff (rst)
        st_stall |-> hs_code == 2'd2);

    // R6: SETUP clears stall and sets NAK
    p_setup_effect_r6: assert property (@(posedge clk) disable iff (rst)
        core_setup |=> (!st_stall && st_nak));

    // R4: disable request ignored without enable
    p_dis_needs_en_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == '0 && reg_wdata[1] && !st_en && !st_dis) |=> !st_dis);

    // R3: transfer flag appears only after enable has dropped
    p_xfer_flag_late_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_xfer_cmpl) |-> !$past(st_en));

    // R4: disabled flag appears only after request has dropped
    p_dis_flag_late_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_ep_dis) |-> !$past(st_dis));

    // R10: no masked-off endpoint interrupt
    p_txf_masked_r10: assert property (@(posedge clk) disable iff (rst)
        (irq_txf_empty & ~txf_mask) == '0);

endmodule

bind inep_ctrl_hs inep_hs_chk #(.NUM_EP(NUM_EP), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .core_setup    (core_setup),
    .hs_code       (hs_code),
    .irq_ep_dis    (irq_ep_dis),
    .irq_xfer_cmpl (irq_xfer_cmpl),
    .irq_txf_empty (irq_txf_empty),
    .st_en         (st.en),
    .st_dis        (st.dis),
    .st_nak        (st.nak),
    .st_stall      (st.stall),
    .txf_mask      (txf_mask)
);

// File: tb/inep_ctrl_hs_bench.sv
module inep_ctrl_hs_bench;

    localparam int NUM_EP = 7;
    localparam int FIFO_W = 4;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;
    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst;
    logic              reg_wr;
    logic [ADDR_W-1:0] reg_addr;
    logic [DATA_W-1:0] reg_wdata;
    logic [ADDR_W-1:0] reg_raddr;
    logic [DATA_W-1:0] reg_rdata;
    logic              core_setup, core_xfer_done, core_dis_done;
    logic              glb_np_in_nak, glb_out_nak;
    logic [NUM_EP-1:0] txf_empty;
    logic [1:0]        hs_code;
    logic              irq_ep_dis, irq_xfer_cmpl;
    logic [NUM_EP-1:0] irq_txf_empty;

    always #(CLK_PERIOD/2) clk = ~clk;

    inep_ctrl_hs #(.NUM_EP(NUM_EP), .FIFO_W(FIFO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_inep_ctrl_hs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .core_setup(core_setup), .core_xfer_done(core_xfer_done),
        .core_dis_done(core_dis_done), .glb_np_in_nak(glb_np_in_nak),
        .glb_out_nak(glb_out_nak), .txf_empty(txf_empty), .hs_code(hs_code),
        .irq_ep_dis(irq_ep_dis), .irq_xfer_cmpl(irq_xfer_cmpl),
        .irq_txf_empty(irq_txf_empty)
    );

    // reference state
    bit              m_en, m_dis, m_nak, m_stall;
    bit [FIFO_W-1:0] m_fifo;
    bit [NUM_EP-1:0] m_mask;
    bit [1:0]        m_flags, m_pend;
    bit              last_setup;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FIFO-free FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] exp_hs();
        if (m_stall) return 2'd2;
        if (m_nak || glb_np_in_nak || glb_out_nak) return 2'd1;
        if (m_en) return 2'd0;
        return 2'd1;
    endfunction

    task automatic compare_all();
        reg_raddr = 2'd0; #1;
        check("R2 enable", 32'(reg_rdata[0]), 32'(m_en));
        check("R4 disable", 32'(reg_rdata[1]), 32'(m_dis));
        check("R5 strobes read zero", 32'(reg_rdata[3:2]), 32'd0);
        check("R5 nak status", 32'(reg_rdata[16]), 32'(m_nak));
        check(last_setup ? "R6 stall after setup" : "R7 stall", 32'(reg_rdata[4]), 32'(m_stall));
        check("R9 fifo number", 32'(reg_rdata[11:8]), 32'(m_fifo));
        check("R9 reserved ctl", reg_rdata & ~32'h0001_0F13, 32'd0);
        reg_raddr = 2'd1; #1;
        check("R11 flags", reg_rdata, 32'(m_flags));
        reg_raddr = 2'd2; #1;
        check("R10 mask", reg_rdata, 32'(m_mask));
        reg_raddr = 2'd3; #1;
        check("R9 unused address", reg_rdata, 32'd0);
        check("R3 irq_xfer_cmpl", 32'(irq_xfer_cmpl), 32'(m_flags[1]));
        check("R4 irq_ep_dis", 32'(irq_ep_dis), 32'(m_flags[0]));
        check("R8 handshake", 32'(hs_code), 32'(exp_hs()));
        check("R10 txf irq", 32'(irq_txf_empty), 32'(txf_empty & m_mask));
    endtask

    // called at the negative edge: checks current state, drives inputs,
    // advances the reference, then waits for the next negative edge
    task automatic cyc(input bit wr, input int addr, input logic [31:0] d,
                       input bit su, input bit xd, input bit dd);
        bit wc, wi, wm;
        bit en_n, dis_n, nak_n, stall_n;
        compare_all();
        reg_wr = wr; reg_addr = ADDR_W'(addr); reg_wdata = d;
        core_setup = su; core_xfer_done = xd; core_dis_done = dd;
        wc = wr && addr == 0; wi = wr && addr == 1; wm = wr && addr == 2;
        en_n = m_en | (wc & d[0]);
        dis_n = m_dis | (wc & d[1] & m_en);
        nak_n = m_nak;
        if (wc && d[3]) nak_n = 1'b0;
        if (wc && d[2]) nak_n = 1'b1;
        stall_n = m_stall | (wc & d[4]);
        if (su) begin nak_n = 1'b1; stall_n = 1'b0; end
        m_flags = (m_flags & ~(wi ? d[1:0] : 2'b00)) | m_pend;
        m_pend = 2'b00;
        if (xd && m_en) begin en_n = 1'b0; m_pend[1] = 1'b1; end
        if (dd && m_dis) begin en_n = 1'b0; dis_n = 1'b0; m_pend[0] = 1'b1; end
        if (wc) m_fifo = d[11:8];
        if (wm) m_mask = d[NUM_EP-1:0];
        m_en = en_n; m_dis = dis_n; m_nak = nak_n; m_stall = stall_n;
        last_setup = su;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2718));
        rst = 1'b1; reg_wr = 0; reg_addr = '0; reg_wdata = '0; reg_raddr = '0;
        core_setup = 0; core_xfer_done = 0; core_dis_done = 0;
        glb_np_in_nak = 0; glb_out_nak = 0; txf_empty = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        reg_raddr = 2'd0; #1; check("R1 ctl after reset", reg_rdata, 32'd0);
        reg_raddr = 2'd1; #1; check("R1 flags after reset", reg_rdata, 32'd0);
        reg_raddr = 2'd2; #1; check("R1 mask after reset", reg_rdata, 32'd0);
        check("R1 handshake after reset", 32'(hs_code), 32'd1);
        check("R1 irqs after reset", {30'd0, irq_ep_dis, irq_xfer_cmpl}, 32'd0);

        // directed corner cases
        cyc(1, 0, 32'h0000_0002, 0, 0, 0);   // R4 disable without enable ignored
        cyc(1, 0, 32'h0000_0501, 0, 0, 0);   // R2 enable, R9 fifo=5
        cyc(1, 0, 32'h0000_0000, 0, 0, 0);   // R2 writing 0 keeps enable
        cyc(1, 2, 32'h0000_0055, 0, 0, 0);   // R10 mask
        cyc(1, 0, 32'h0000_000C, 0, 0, 0);   // R5 set+clear together: set wins
        cyc(1, 0, 32'h0000_0008, 0, 0, 0);   // R5 clear
        glb_out_nak = 1;
        cyc(0, 0, 32'h0, 0, 0, 0);           // R8 global NAK
        glb_out_nak = 0;
        cyc(1, 0, 32'h0000_0010, 1, 0, 0);   // R6 setup beats stall write
        cyc(1, 0, 32'h0000_0018, 0, 0, 0);   // R7 stall set over nak clear
        cyc(1, 0, 32'h0000_0000, 0, 0, 0);   // R7 zero write keeps stall
        cyc(0, 0, 32'h0, 1, 0, 0);           // R6 setup clears stall
        cyc(1, 0, 32'h0000_0001, 0, 1, 0);   // R3 hw clear vs sw set
        cyc(0, 0, 32'h0, 0, 0, 0);
        cyc(1, 1, 32'h0000_0002, 0, 0, 0);   // R11 clear
        cyc(1, 0, 32'h0000_0001, 0, 0, 0);
        cyc(0, 0, 32'h0, 0, 1, 0);           // R3 complete
        cyc(1, 1, 32'h0000_0002, 0, 0, 0);   // R11 raise wins over clear
        cyc(0, 0, 32'h0, 0, 0, 0);
        cyc(1, 0, 32'h0000_0001, 0, 0, 0);
        cyc(1, 0, 32'h0000_0002, 0, 0, 0);   // R4 disable with enable
        cyc(0, 0, 32'h0, 0, 0, 1);           // R4 disable done
        cyc(0, 0, 32'h0, 0, 0, 0);
        cyc(1, 1, 32'h0000_0003, 0, 0, 0);

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            bit wr;
            int addr;
            logic [31:0] d;
            wr = ($urandom % 2) == 0;
            addr = $urandom % 4;
            d = $urandom;
            if (($urandom % 3) != 0) d = d & 32'h0000_0F1F;
            glb_np_in_nak = ($urandom % 8) == 0;
            glb_out_nak = ($urandom % 8) == 0;
            txf_empty = NUM_EP'($urandom);
            cyc(wr, addr, d, ($urandom % 12) == 0, ($urandom % 5) == 0,
                ($urandom % 4) == 0);
        end
        compare_all();
        finish_run();
    end

endmodule